// File: doc/BRIEF.md
# Parallel Display Bus Master

This block is the host side of an 8-bit parallel display-controller bus in 8080 style. A client issues one 16-bit request at a time on a valid/ready handshake. The request is a command word, a data-word write, a data-word read, or a panel reset. The block turns each word into two byte transfers, upper byte first. It asserts chip select around the whole request and drives the command/data select line. It times every strobe phase in system clock cycles.

Writes place the byte on the bus with the output enable raised. After a setup interval the write strobe pulses low, and an idle interval follows before the next byte. Reads release the bus one cycle before the read strobe falls. The read strobe is held low for longer than a write strobe. The input byte is captured at a programmable cycle inside that low phase, and both captured bytes are returned as one word with a one-cycle completion pulse. A panel reset request pulls the reset line low for a set number of cycles and touches nothing else. All phase lengths are parameters with a minimum of one cycle, so the same block can be tuned for any system clock rate.

Top module: `disp_bus_master`

## Requirements
- R1: Out of reset and whenever idle, chip select, write strobe, read strobe and panel reset are high, command/data select is high, the output enable is low and req_ready is high.
- R2: A write or command word is sent as two byte writes: bits 15:8 first, then bits 7:0. The byte stays on bus_dout, with bus_oe high, for the whole write-strobe low phase.
- R3: bus_dc is low (0 = command) for both bytes of a command request (req_kind 0). It is high for data requests, and high again in the completion cycle.
- R4: Each write strobe is low for exactly WR_LOW cycles. The first byte is driven for WR_SETUP cycles before the strobe falls, and WR_IDLE cycles with the strobe high follow each strobe.
- R5: For a read (req_kind 2), bus_oe is low in the cycle before the read strobe falls and throughout its low phase. Each read strobe is low for exactly RD_LOW cycles and is followed by RD_IDLE high cycles.
- R6: The read byte is captured at the clock edge ending the RD_SAMPLE-th low cycle of the strobe. rd_word returns the first byte in bits 15:8 and the second in bits 7:0, and holds that value until the next read.
- R7: Chip select falls exactly once per write or read request and covers every strobe of that request. It is high again in the completion cycle.
- R8: req_ready is low from the accepting edge until the request completes. done is high for exactly one cycle per request.
- R9: A panel reset request (req_kind 3) drives bus_rst_n low for exactly RST_CYC cycles. It raises no strobe and no chip select.
- R10: Counted from the accepting edge, done rises after 2*(WR_SETUP+WR_LOW+WR_IDLE)+1 cycles for a write, after 2*(RD_LOW+RD_IDLE)+2 for a read, and after RST_CYC+1 for a panel reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_kind | input | 2 | 0 command, 1 data write, 2 data read, 3 panel reset |
| req_word | input | 16 | Word to send for command or write |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 16 | Assembled read word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Command/data select, low = command |
| bus_rst_n | output | 1 | Panel reset, active low |
| bus_dout | output | 8 | Byte driven onto the bus |
| bus_oe | output | 1 | Bus output enable |
| bus_din | input | 8 | Byte read from the bus |

## Verification
Command and data writes are swept over walking-one words and over words with distinct upper and lower bytes, together with all-zeros and all-ones. This shows whether the bytes come out in the right order and whether the select line follows the request type. During reads the bench changes the input byte on every low cycle of the strobe, so only a capture at exactly the intended cycle returns the expected word. Any off-by-one in the sample point or in the byte order gives a different value. Panel resets are placed between bus requests, to show that reset width, completion timing and the absence of strobes hold in any order.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_READ  = 2'd2,
    KIND_RESET = 2'd3
  } dbm_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WLOW,
    ST_WHIGH,
    ST_TURN,
    ST_RLOW,
    ST_RHIGH,
    ST_PANEL_RST,
    ST_FIN
  } dbm_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/disp_bus_timer.sv
module disp_bus_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/disp_bus_ctrl.sv
module disp_bus_ctrl
  import disp_bus_pkg::*;
#(
  parameter int WR_SETUP  = 1,
  parameter int WR_LOW    = 3,
  parameter int WR_IDLE   = 1,
  parameter int RD_LOW    = 8,
  parameter int RD_SAMPLE = 7,
  parameter int RD_IDLE   = 2,
  parameter int RST_CYC   = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  dbm_kind_e        req_kind,
  input  logic [CNT_W-1:0] cnt,
  output dbm_state_e       state,
  output dbm_kind_e        kind,
  output logic             byte_sel,
  output logic             accept,
  output logic             tmr_clr,
  output logic             sample_en
);

  localparam logic [CNT_W-1:0] END_WS  = CNT_W'(WR_SETUP - 1);
  localparam logic [CNT_W-1:0] END_WL  = CNT_W'(WR_LOW - 1);
  localparam logic [CNT_W-1:0] END_WI  = CNT_W'(WR_IDLE - 1);
  localparam logic [CNT_W-1:0] END_RL  = CNT_W'(RD_LOW - 1);
  localparam logic [CNT_W-1:0] END_RI  = CNT_W'(RD_IDLE - 1);
  localparam logic [CNT_W-1:0] END_RS  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] AT_SMP  = CNT_W'(RD_SAMPLE - 1);

  dbm_state_e       state_d;
  dbm_kind_e        kind_d;
  logic             byte_sel_d;
  logic [CNT_W-1:0] phase_end;
  logic             phase_last;

  // Length of the current phase
  always_comb begin
    case (state)
      ST_SETUP:     phase_end = END_WS;
      ST_WLOW:      phase_end = END_WL;
      ST_WHIGH:     phase_end = END_WI;
      ST_RLOW:      phase_end = END_RL;
      ST_RHIGH:     phase_end = END_RI;
      ST_PANEL_RST: phase_end = END_RS;
      default:      phase_end = '0;
    endcase
  end

  assign phase_last = (cnt == phase_end);
  assign accept     = (state == ST_IDLE) && req_valid;
  assign sample_en  = (state == ST_RLOW) && (cnt == AT_SMP);
  assign tmr_clr    = (state_d != state);

  // Next-state process
  always_comb begin
    state_d    = state;
    kind_d     = kind;
    byte_sel_d = byte_sel;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          kind_d     = req_kind;
          byte_sel_d = 1'b0;
          case (req_kind)
            KIND_READ:  state_d = ST_TURN;
            KIND_RESET: state_d = ST_PANEL_RST;
            default:    state_d = ST_SETUP;
          endcase
        end
      end
      ST_SETUP: if (phase_last) state_d = ST_WLOW;
      ST_WLOW:  if (phase_last) state_d = ST_WHIGH;
      ST_WHIGH: begin
        if (phase_last) begin
          if (byte_sel) state_d = ST_FIN;
          else begin
            state_d    = ST_SETUP;
            byte_sel_d = 1'b1;
          end
        end
      end
      ST_TURN:  state_d = ST_RLOW;
      ST_RLOW:  if (phase_last) state_d = ST_RHIGH;
      ST_RHIGH: begin
        if (phase_last) begin
          if (byte_sel) state_d = ST_FIN;
          else begin
            state_d    = ST_RLOW;
            byte_sel_d = 1'b1;
          end
        end
      end
      ST_PANEL_RST: if (phase_last) state_d = ST_FIN;
      ST_FIN:       state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= KIND_WRITE;
      byte_sel <= 1'b0;
    end else begin
      state    <= state_d;
      kind     <= kind_d;
      byte_sel <= byte_sel_d;
    end
  end

endmodule

// File: rtl/disp_bus_datapath.sv
module disp_bus_datapath #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] req_word,
  input  logic              byte_sel,
  input  logic              sample_en,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] wr_word_q;
  logic [WORD_W-1:0] rd_word_d;

  // Upper lane goes out first
  assign bus_dout = byte_sel ? wr_word_q[BYTE_W-1:0] : wr_word_q[WORD_W-1:BYTE_W];

  always_comb begin
    rd_word_d = rd_word;
    if (sample_en) begin
      if (byte_sel) rd_word_d[BYTE_W-1:0]      = bus_din;
      else          rd_word_d[WORD_W-1:BYTE_W] = bus_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_word_q <= '0;
      rd_word   <= '0;
    end else begin
      if (accept) wr_word_q <= req_word;
      rd_word <= rd_word_d;
    end
  end

endmodule

// File: rtl/disp_bus_master.sv
module disp_bus_master
  import disp_bus_pkg::*;
#(
  parameter int WR_SETUP  = 1,
  parameter int WR_LOW    = 3,
  parameter int WR_IDLE   = 1,
  parameter int RD_LOW    = 8,
  parameter int RD_SAMPLE = 7,
  parameter int RD_IDLE   = 2,
  parameter int RST_CYC   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_word,
  output logic        done,
  output logic [15:0] rd_word,
  output logic        bus_cs_n,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        bus_dc,
  output logic        bus_rst_n,
  output logic [7:0]  bus_dout,
  output logic        bus_oe,
  input  logic [7:0]  bus_din
);

  localparam int BYTE_W = 8;
  localparam int MAX_PH = max_int(max_int(max_int(WR_SETUP, WR_LOW), max_int(WR_IDLE, RD_LOW)),
                                  max_int(RD_IDLE, RST_CYC));
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  dbm_state_e       state;
  dbm_kind_e        kind;
  logic             byte_sel;
  logic             accept;
  logic             tmr_clr;
  logic             sample_en;
  logic [CNT_W-1:0] cnt;
  logic             wr_phase;

  disp_bus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (cnt)
  );

  disp_bus_ctrl #(
    .WR_SETUP (WR_SETUP), .WR_LOW (WR_LOW), .WR_IDLE (WR_IDLE),
    .RD_LOW (RD_LOW), .RD_SAMPLE (RD_SAMPLE), .RD_IDLE (RD_IDLE),
    .RST_CYC (RST_CYC), .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (dbm_kind_e'(req_kind)),
    .cnt       (cnt),
    .state     (state),
    .kind      (kind),
    .byte_sel  (byte_sel),
    .accept    (accept),
    .tmr_clr   (tmr_clr),
    .sample_en (sample_en)
  );

  disp_bus_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_word  (req_word),
    .byte_sel  (byte_sel),
    .sample_en (sample_en),
    .bus_din   (bus_din),
    .bus_dout  (bus_dout),
    .rd_word   (rd_word)
  );

  // Pin levels decoded from the registered state
  assign wr_phase  = (state == ST_SETUP) || (state == ST_WLOW) || (state == ST_WHIGH);
  assign bus_oe    = wr_phase;
  assign bus_cs_n  = !(wr_phase || (state == ST_TURN) || (state == ST_RLOW) || (state == ST_RHIGH));
  assign bus_wr_n  = (state != ST_WLOW);
  assign bus_rd_n  = (state != ST_RLOW);
  assign bus_rst_n = (state != ST_PANEL_RST);
  assign bus_dc    = !(wr_phase && (kind == KIND_CMD));
  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_FIN);

endmodule

// File: rtl/disp_bus_master_chk.sv
module disp_bus_master_chk #(
  parameter int WR_LOW  = 3,
  parameter int RD_LOW  = 8,
  parameter int RST_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       bus_cs_n,
  input logic       bus_wr_n,
  input logic       bus_rd_n,
  input logic       bus_dc,
  input logic       bus_rst_n,
  input logic [7:0] bus_dout,
  input logic       bus_oe
);

  int wr_run, rd_run, rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run  <= 0;
      rd_run  <= 0;
      rst_run <= 0;
    end else begin
      wr_run  <= bus_wr_n  ? 0 : wr_run + 1;
      rd_run  <= bus_rd_n  ? 0 : rd_run + 1;
      rst_run <= bus_rst_n ? 0 : rst_run + 1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_wr_n && bus_rd_n && bus_rst_n && bus_dc && !bus_oe));

  p_wr_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_dout) && bus_oe));

  p_dc_cmd_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dc |-> bus_oe);

  p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (wr_run == WR_LOW));

  p_rd_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> (rd_run == RD_LOW));

  p_rd_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |-> (!bus_oe && $past(!bus_oe)));

  p_rd_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

  p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rst_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |-> (bus_cs_n && bus_wr_n && bus_rd_n));

  p_rst_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_n) |-> (rst_run == RST_CYC));

endmodule

bind disp_bus_master disp_bus_master_chk #(
  .WR_LOW (WR_LOW), .RD_LOW (RD_LOW), .RST_CYC (RST_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .bus_cs_n  (bus_cs_n),
  .bus_wr_n  (bus_wr_n),
  .bus_rd_n  (bus_rd_n),
  .bus_dc    (bus_dc),
  .bus_rst_n (bus_rst_n),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe)
);

// File: tb/disp_bus_master_test.sv
`timescale 1ns/1ps
module disp_bus_master_test;

  localparam int WS = 2, WL = 3, WI = 1, RL = 5, RS = 4, RI = 2, RC = 6;

  logic        clk, rst_n;
  logic        req_valid, req_ready, done;
  logic [1:0]  req_kind;
  logic [15:0] req_word, rd_word;
  logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_dc, bus_rst_n, bus_oe;
  logic [7:0]  bus_dout, bus_din;

  int checks, failures;

  disp_bus_master #(
    .WR_SETUP (WS), .WR_LOW (WL), .WR_IDLE (WI),
    .RD_LOW (RL), .RD_SAMPLE (RS), .RD_IDLE (RI), .RST_CYC (RC)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_kind (req_kind), .req_word (req_word),
    .done (done), .rd_word (rd_word),
    .bus_cs_n (bus_cs_n), .bus_wr_n (bus_wr_n), .bus_rd_n (bus_rd_n),
    .bus_dc (bus_dc), .bus_rst_n (bus_rst_n),
    .bus_dout (bus_dout), .bus_oe (bus_oe), .bus_din (bus_din)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bus-side monitor and read-data model
  logic [7:0]  wbyte [2];
  logic        wdc   [2];
  int          wwid  [2];
  int          rwid  [2];
  int          nw, nr, wr_run, rd_run, rst_run, rst_w, setup_run, cs_falls, ndone;
  int          oe_bad, wr_bad;
  logic        prev_wr, prev_rd, prev_oe, prev_cs, prev_rst, last_dc;
  logic [7:0]  last_dout;
  logic [15:0] rd_model;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_wr = 1'b1; prev_rd = 1'b1; prev_oe = 1'b0; prev_cs = 1'b1; prev_rst = 1'b1;
      nw = 0; nr = 0; wr_run = 0; rd_run = 0; rst_run = 0; rst_w = 0;
      setup_run = 0; cs_falls = 0; ndone = 0; oe_bad = 0; wr_bad = 0;
      bus_din = 8'h00;
    end else begin
      if (req_valid && req_ready) begin
        nw = 0; nr = 0; rst_w = 0; setup_run = 0; cs_falls = 0; ndone = 0;
        oe_bad = 0; wr_bad = 0;
      end
      if (bus_oe && bus_wr_n && nw == 0 && wr_run == 0) setup_run++;
      if (!bus_wr_n) begin
        wr_run++;
        if (!bus_oe || bus_cs_n) wr_bad++;
        last_dout = bus_dout;
        last_dc   = bus_dc;
      end else if (!prev_wr) begin
        if (nw < 2) begin
          wbyte[nw] = last_dout; wdc[nw] = last_dc; wwid[nw] = wr_run;
        end
        nw++;
        wr_run = 0;
      end
      if (!bus_rd_n) begin
        if (rd_run == 0 && prev_oe) oe_bad++;
        if (bus_oe || bus_cs_n) oe_bad++;
        rd_run++;
        bus_din = 8'((nr == 0 ? rd_model[15:8] : rd_model[7:0]) + rd_run - RS);
      end else if (!prev_rd) begin
        if (nr < 2) rwid[nr] = rd_run;
        nr++;
        rd_run = 0;
      end
      if (!bus_rst_n) rst_run++;
      else if (!prev_rst) begin rst_w = rst_run; rst_run = 0; end
      if (!bus_cs_n && prev_cs) cs_falls++;
      if (done) ndone++;
      prev_wr = bus_wr_n; prev_rd = bus_rd_n; prev_oe = bus_oe;
      prev_cs = bus_cs_n; prev_rst = bus_rst_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] kind, input logic [15:0] word);
    int lat;
    int busy_bad;
    int exp_lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_word = word; rd_model = word;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; busy_bad = 0;
    while (!done && lat < 500) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      lat++;
    end
    #1;
    exp_lat = (kind == 2'd3) ? RC + 1 : (kind == 2'd2) ? 2 * (RL + RI) + 2 : 2 * (WS + WL + WI) + 1;
    chk(lat == exp_lat, "R10 latency", lat, exp_lat);
    chk(busy_bad == 0, "R8 ready low while busy", busy_bad, 0);
    chk(bus_cs_n && bus_dc, "R7/R3 cs and dc high at completion", {bus_cs_n, bus_dc}, 2'b11);
    if (kind <= 2'd1) begin
      chk(nw == 2 && nr == 0, "R2 two byte writes", nw, 2);
      chk(wbyte[0] == word[15:8], "R2 first byte is upper", wbyte[0], word[15:8]);
      chk(wbyte[1] == word[7:0], "R2 second byte is lower", wbyte[1], word[7:0]);
      chk(wdc[0] == (kind != 2'd0) && wdc[1] == (kind != 2'd0), "R3 dc level per byte",
          {wdc[0], wdc[1]}, (kind != 2'd0) ? 2'b11 : 2'b00);
      chk(wwid[0] == WL && wwid[1] == WL, "R4 write strobe width", wwid[0], WL);
      chk(setup_run == WS, "R4 setup before first strobe", setup_run, WS);
      chk(wr_bad == 0, "R2 bus driven and cs low during strobe", wr_bad, 0);
      chk(cs_falls == 1, "R7 single chip-select window", cs_falls, 1);
    end else if (kind == 2'd2) begin
      chk(nr == 2 && nw == 0, "R5 two byte reads", nr, 2);
      chk(rwid[0] == RL && rwid[1] == RL, "R5 read strobe width", rwid[0], RL);
      chk(oe_bad == 0, "R5 bus released around read strobe", oe_bad, 0);
      chk(rd_word == word, "R6 read word assembly and sample point", rd_word, word);
      chk(cs_falls == 1, "R7 single chip-select window", cs_falls, 1);
    end else begin
      chk(rst_w == RC, "R9 reset low width", rst_w, RC);
      chk(nw == 0 && nr == 0 && cs_falls == 0, "R9 no strobe or select during reset",
          nw + nr + cs_falls, 0);
    end
    @(negedge clk);
    #1;
    chk(!done && ndone == 1 && req_ready, "R8 single done pulse then ready", ndone, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_word = 16'h0; rd_model = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(bus_cs_n && bus_wr_n && bus_rd_n && bus_rst_n && bus_dc && !bus_oe && req_ready && !done,
        "R1 idle levels after reset",
        {bus_cs_n, bus_wr_n, bus_rd_n, bus_rst_n, bus_dc, bus_oe, req_ready, done}, 8'b11111010);

    run_req(2'd0, 16'h0000);
    run_req(2'd0, 16'hFFFF);
    for (int i = 0; i < 16; i++) run_req(2'd0, 16'(i * 16'h1111) ^ 16'h8421);
    for (int i = 0; i < 16; i++) run_req(2'd1, 16'h0001 << i);
    run_req(2'd3, 16'h0000);
    for (int i = 0; i < 16; i++) run_req(2'd2, 16'(i * 16'h0F0F) ^ 16'hC3A5);
    run_req(2'd2, 16'h0000);
    run_req(2'd2, 16'hFFFF);
    run_req(2'd1, 16'hA55A);
    run_req(2'd3, 16'h0000);
    run_req(2'd0, 16'h2C00);

    @(negedge clk); #1;
    chk(rd_word == 16'hFFFF, "R6 read word held after other requests", rd_word, 16'hFFFF);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule